// File: doc/BRIEF.md
# Coherent Port Activity Event Tap

This block watches the channel handshakes of the slave ports and master ports of a coherent AXI/ACE-style interconnect, and turns them into single-cycle event pulses for a performance counter bank. Every slave port yields a 32-bit event vector and every master port a 7-bit vector. Each bit of a vector stands for one event code. The block does not decode transactions. The request class, the last-beat flag, the snoop-hit flag, bit 0 of the snoop response and the non-secure protection bit all arrive on sideband pins that are already decoded.

A debug-authentication gate sits between event detection and the output register. An event whose transaction is Secure is withheld unless observation of Secure traffic is authorised. The exempt events pass in every case: these are the data-channel and response-channel events, which carry no security attribute. The outputs are merged into one exported bus. The 16 chip-wide global events come first, then the master vectors, then the slave vectors.

The block is a passive tap. It drives no READY and samples every channel without ever back-pressuring it. A handshake is counted in any cycle where VALID and READY are both high, and a stall in any cycle where VALID is high and READY is low. The event bus has no handshake of its own: each bit is a one-cycle pulse that the consumer must take in the cycle it appears.

Top module: `coh_evt_tap`

## Requirements
- R1: Event codes 0x00 to 0x07 come from the read address channel of a slave port. A read address handshake raises bit 0x00. It also raises bit 0x01+c, where c is the 3-bit read class: 0 device, 1 normal non-shareable, 2 shareable non-allocating, 3 shareable allocating, 4 invalidation, 5 cache maintenance, 6 DVM. Class 7 raises no class bit.
- R2: Event codes 0x08 and 0x09 come from the read data channel of a slave port. A read data handshake raises bit 0x08. If the last flag and the snoop-hit flag are also both high, it raises bit 0x09 as well.
- R3: Event codes 0x0A to 0x10 come from the write address channel of a slave port. A write address handshake raises bit 0x0A. It also raises bit 0x0B+c, where c is the 3-bit write class: 0 device, 1 non-shareable, 2 shareable write-back/clean, 3 shareable full-line unique, 4 shareable unique, 5 evict. Class 7 raises no class bit.
- R4: Write class 6 (write-evict) is not supported. Bit 0x11 never rises, while bit 0x0A still rises for that handshake.
- R5: The write data and snoop channels of a slave port raise the following bits on a handshake:
  - a write data handshake raises bit 0x12;
  - a snoop request handshake raises bit 0x13;
  - it also raises bit 0x14 for snoop class 0 (read type) and bit 0x15 for snoop class 1 (clean/invalidate), where the snoop class is 2 bits wide;
  - a snoop response handshake with response bit 0 low raises bit 0x16.
- R6: Stall bits on a slave port:
  - bits 0x17 to 0x1D are stalls on, in order: read address, read data, write address, write data, write response, snoop request and snoop data;
  - bits 0x1E and 0x1F copy the outstanding-limit stall input and the read arbitration stall input.
- R7: Observation of Secure traffic is permitted when the Secure-observe input is high, or when the debug-enable and Secure-debug inputs are both high. Otherwise an event that is not exempt and belongs to a Secure transaction is dropped.
- R8: Slave bits 0x08, 0x09, 0x12, 0x16, 0x18, 0x1A, 0x1B and 0x1D are exempt and pass whatever the security state. Master bits 0, 1, 3, 5 and 6 are also exempt.
- R9: Where an event's security comes from:
  - events of the read address, write address and snoop request channels take the non-secure bit driven in that same cycle on their channel;
  - bit 0x1E takes the non-secure bit of the most recent request handshake, with read winning when read and write occur in the same cycle;
  - bit 0x1F takes the non-secure bit of the most recent read address handshake;
  - both of these held values reset to Secure.
- R10: Each master port raises seven bits:
  - bit 0 for a read data handshake and bit 1 for a write data handshake;
  - bits 2 to 6 for stalls on read address, read data, write address, write data and write response;
  - bits 2 and 4 take their channel's non-secure bit.
- R11: The bus layout is fixed:
  - bus bits [15:0] carry the global event inputs;
  - master port m occupies bits [16+7m +: 7];
  - slave port s occupies bits [16+7M+32s +: 32], where M is the master port count;
  - every bit appears exactly one cycle after its qualifying input cycle.
- R12: While reset is asserted, and in the first cycle after it, the whole event bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_en | input | 1 | Debug enable |
| sec_dbg_en | input | 1 | Secure debug enable, effective together with dbg_en |
| sec_observe_en | input | 1 | Secure non-invasive observation enable |
| glb_evt | input | 16 | Global event pulses |
| m_ar_valid | input | NUM_MST | Master read address VALID |
| m_ar_ready | input | NUM_MST | Master read address READY |
| m_ar_ns | input | NUM_MST | Master read address non-secure bit |
| m_r_valid | input | NUM_MST | Master read data VALID |
| m_r_ready | input | NUM_MST | Master read data READY |
| m_aw_valid | input | NUM_MST | Master write address VALID |
| m_aw_ready | input | NUM_MST | Master write address READY |
| m_aw_ns | input | NUM_MST | Master write address non-secure bit |
| m_w_valid | input | NUM_MST | Master write data VALID |
| m_w_ready | input | NUM_MST | Master write data READY |
| m_b_valid | input | NUM_MST | Master write response VALID |
| m_b_ready | input | NUM_MST | Master write response READY |
| s_ar_valid | input | NUM_SLV | Slave read address VALID |
| s_ar_ready | input | NUM_SLV | Slave read address READY |
| s_ar_cls | input | NUM_SLV x 3 | Slave read class |
| s_ar_ns | input | NUM_SLV | Slave read address non-secure bit |
| s_r_valid | input | NUM_SLV | Slave read data VALID |
| s_r_ready | input | NUM_SLV | Slave read data READY |
| s_r_last | input | NUM_SLV | Slave read data last beat |
| s_r_snp_hit | input | NUM_SLV | Slave read data snoop hit |
| s_aw_valid | input | NUM_SLV | Slave write address VALID |
| s_aw_ready | input | NUM_SLV | Slave write address READY |
| s_aw_cls | input | NUM_SLV x 3 | Slave write class |
| s_aw_ns | input | NUM_SLV | Slave write address non-secure bit |
| s_w_valid | input | NUM_SLV | Slave write data VALID |
| s_w_ready | input | NUM_SLV | Slave write data READY |
| s_b_valid | input | NUM_SLV | Slave write response VALID |
| s_b_ready | input | NUM_SLV | Slave write response READY |
| s_ac_valid | input | NUM_SLV | Slave snoop request VALID |
| s_ac_ready | input | NUM_SLV | Slave snoop request READY |
| s_ac_cls | input | NUM_SLV x 2 | Slave snoop class |
| s_ac_ns | input | NUM_SLV | Slave snoop non-secure bit |
| s_cr_valid | input | NUM_SLV | Slave snoop response VALID |
| s_cr_ready | input | NUM_SLV | Slave snoop response READY |
| s_cr_resp0 | input | NUM_SLV | Slave snoop response bit 0 |
| s_cd_valid | input | NUM_SLV | Slave snoop data VALID |
| s_cd_ready | input | NUM_SLV | Slave snoop data READY |
| s_ot_stall | input | NUM_SLV | Slave outstanding-limit stall |
| s_arb_stall | input | NUM_SLV | Slave read arbitration stall |
| evt_bus | output | 16+7*NUM_MST+32*NUM_SLV | Registered event bus |

## Verification
The hardest case to reach is the pair of external stall bits 0x1E and 0x1F. Their security comes from a handshake that happened earlier, not from anything driven in the same cycle. They are only observable while the gate is closed, and before any handshake they must show the reset Secure state. The stimulus covers this in two ways. A directed prologue raises both stall inputs with the gate closed before any request has been accepted. A long sweep then walks through four authorisation phases while the read and write request channels keep changing security. The bench keeps its own copy of the two remembered bits and predicts each stall pulse from them.

// File: rtl/cet_pkg.sv
package cet_pkg;

  localparam int GLB_W = 16;
  localparam int MST_W = 7;
  localparam int SLV_W = 32;

  // slave event codes
  localparam int EV_AR_HS   = 0;
  localparam int EV_AR_CLS0 = 1;
  localparam int EV_R_HS    = 8;
  localparam int EV_R_HIT   = 9;
  localparam int EV_AW_HS   = 10;
  localparam int EV_AW_CLS0 = 11;
  localparam int EV_WEVICT  = 17;
  localparam int EV_W_HS    = 18;
  localparam int EV_AC_HS   = 19;
  localparam int EV_AC_RD   = 20;
  localparam int EV_AC_CI   = 21;
  localparam int EV_CR_DT   = 22;
  localparam int EV_AR_ST   = 23;
  localparam int EV_R_ST    = 24;
  localparam int EV_AW_ST   = 25;
  localparam int EV_W_ST    = 26;
  localparam int EV_B_ST    = 27;
  localparam int EV_AC_ST   = 28;
  localparam int EV_CD_ST   = 29;
  localparam int EV_OT_ST   = 30;
  localparam int EV_ARB_ST  = 31;

  localparam int RD_CLS_N = 7;  // classes 0..6 counted
  localparam int WR_CLS_N = 6;  // classes 0..5 counted, 6 is write-evict

  // master event codes
  localparam int MEV_R_HS  = 0;
  localparam int MEV_W_HS  = 1;
  localparam int MEV_AR_ST = 2;
  localparam int MEV_R_ST  = 3;
  localparam int MEV_AW_ST = 4;
  localparam int MEV_W_ST  = 5;
  localparam int MEV_B_ST  = 6;

  localparam logic [SLV_W-1:0] SLV_EXEMPT =
      (SLV_W'(1) << EV_R_HS)  | (SLV_W'(1) << EV_R_HIT) |
      (SLV_W'(1) << EV_W_HS)  | (SLV_W'(1) << EV_CR_DT) |
      (SLV_W'(1) << EV_R_ST)  | (SLV_W'(1) << EV_W_ST)  |
      (SLV_W'(1) << EV_B_ST)  | (SLV_W'(1) << EV_CD_ST);

  localparam logic [MST_W-1:0] MST_EXEMPT =
      (MST_W'(1) << MEV_R_HS) | (MST_W'(1) << MEV_W_HS) |
      (MST_W'(1) << MEV_R_ST) | (MST_W'(1) << MEV_W_ST) |
      (MST_W'(1) << MEV_B_ST);

  typedef enum logic [1:0] {
    SNP_READ  = 2'd0,
    SNP_CLINV = 2'd1,
    SNP_OTH2  = 2'd2,
    SNP_OTH3  = 2'd3
  } snp_cls_e;

endpackage

// File: rtl/cet_slv_src.sv
module cet_slv_src
  import cet_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic [2:0]       ar_cls,
  input  logic             ar_ns,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             r_last,
  input  logic             r_snp_hit,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic [2:0]       aw_cls,
  input  logic             aw_ns,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             b_valid,
  input  logic             b_ready,
  input  logic             ac_valid,
  input  logic             ac_ready,
  input  logic [1:0]       ac_cls,
  input  logic             ac_ns,
  input  logic             cr_valid,
  input  logic             cr_ready,
  input  logic             cr_resp0,
  input  logic             cd_valid,
  input  logic             cd_ready,
  input  logic             ot_stall,
  input  logic             arb_stall,
  output logic [SLV_W-1:0] raw,
  output logic [SLV_W-1:0] ns
);

  logic ar_hs, r_hs, aw_hs, w_hs, ac_hs, cr_hs;
  logic last_req_ns, last_ar_ns;
  snp_cls_e snp;

  assign ar_hs = ar_valid & ar_ready;
  assign r_hs  = r_valid  & r_ready;
  assign aw_hs = aw_valid & aw_ready;
  assign w_hs  = w_valid  & w_ready;
  assign ac_hs = ac_valid & ac_ready;
  assign cr_hs = cr_valid & cr_ready;
  assign snp   = snp_cls_e'(ac_cls);

  // remembered security of accepted requests, reset to Secure
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ar_ns  <= 1'b0;
      last_req_ns <= 1'b0;
    end else begin
      if (ar_hs) last_ar_ns <= ar_ns;
      if (ar_hs)      last_req_ns <= ar_ns;
      else if (aw_hs) last_req_ns <= aw_ns;
    end
  end

  always_comb begin
    raw = '0;
    raw[EV_AR_HS] = ar_hs;
    for (int k = 0; k < RD_CLS_N; k++)
      raw[EV_AR_CLS0 + k] = ar_hs && (ar_cls == 3'(k));
    raw[EV_R_HS]  = r_hs;
    raw[EV_R_HIT] = r_hs && r_last && r_snp_hit;
    raw[EV_AW_HS] = aw_hs;
    for (int k = 0; k < WR_CLS_N; k++)
      raw[EV_AW_CLS0 + k] = aw_hs && (aw_cls == 3'(k));
    raw[EV_WEVICT] = 1'b0;
    raw[EV_W_HS]   = w_hs;
    raw[EV_AC_HS]  = ac_hs;
    raw[EV_AC_RD]  = ac_hs && (snp == SNP_READ);
    raw[EV_AC_CI]  = ac_hs && (snp == SNP_CLINV);
    raw[EV_CR_DT]  = cr_hs && !cr_resp0;
    raw[EV_AR_ST]  = ar_valid && !ar_ready;
    raw[EV_R_ST]   = r_valid  && !r_ready;
    raw[EV_AW_ST]  = aw_valid && !aw_ready;
    raw[EV_W_ST]   = w_valid  && !w_ready;
    raw[EV_B_ST]   = b_valid  && !b_ready;
    raw[EV_AC_ST]  = ac_valid && !ac_ready;
    raw[EV_CD_ST]  = cd_valid && !cd_ready;
    raw[EV_OT_ST]  = ot_stall;
    raw[EV_ARB_ST] = arb_stall;
  end

  always_comb begin
    ns = '1;
    for (int k = EV_AR_HS; k <= EV_AR_CLS0 + RD_CLS_N - 1; k++) ns[k] = ar_ns;
    ns[EV_AR_ST] = ar_ns;
    for (int k = EV_AW_HS; k <= EV_WEVICT; k++) ns[k] = aw_ns;
    ns[EV_AW_ST] = aw_ns;
    ns[EV_AC_HS] = ac_ns;
    ns[EV_AC_RD] = ac_ns;
    ns[EV_AC_CI] = ac_ns;
    ns[EV_AC_ST] = ac_ns;
    ns[EV_OT_ST]  = last_req_ns;
    ns[EV_ARB_ST] = last_ar_ns;
  end

  // R2: a snoop-hit pulse is always a read data handshake
  a_r2_hit_is_hs: assert property (@(posedge clk) disable iff (!rst_n)
    raw[EV_R_HIT] |-> raw[EV_R_HS]);

  // R1: at most one read class bit per cycle
  a_r1_one_class: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(raw[EV_AR_CLS0 +: RD_CLS_N]));

  // R9: held read security follows the last accepted read request
  a_r9_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ar_hs |=> ns[EV_ARB_ST] == $past(ar_ns));

endmodule

// File: rtl/cet_mst_src.sv
module cet_mst_src
  import cet_pkg::*;
(
  input  logic             ar_valid,
  input  logic             ar_ready,
  input  logic             ar_ns,
  input  logic             r_valid,
  input  logic             r_ready,
  input  logic             aw_valid,
  input  logic             aw_ready,
  input  logic             aw_ns,
  input  logic             w_valid,
  input  logic             w_ready,
  input  logic             b_valid,
  input  logic             b_ready,
  output logic [MST_W-1:0] raw,
  output logic [MST_W-1:0] ns
);

  always_comb begin
    raw = '0;
    raw[MEV_R_HS]  = r_valid  && r_ready;
    raw[MEV_W_HS]  = w_valid  && w_ready;
    raw[MEV_AR_ST] = ar_valid && !ar_ready;
    raw[MEV_R_ST]  = r_valid  && !r_ready;
    raw[MEV_AW_ST] = aw_valid && !aw_ready;
    raw[MEV_W_ST]  = w_valid  && !w_ready;
    raw[MEV_B_ST]  = b_valid  && !b_ready;
  end

  always_comb begin
    ns = '1;
    ns[MEV_AR_ST] = ar_ns;
    ns[MEV_AW_ST] = aw_ns;
  end

endmodule

// File: rtl/cet_sec_gate.sv
module cet_sec_gate #(
  parameter int          W      = 32,
  parameter logic [W-1:0] EXEMPT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         permit,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] ns,
  output logic [W-1:0] evt
);

  logic [W-1:0] pass;

  assign pass = raw & (EXEMPT | ns | {W{permit}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt <= '0;
    else        evt <= pass;
  end

  // R7: closed gate never lets a Secure non-exempt event out
  a_r7_drop_secure: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |=> (evt & $past(~ns & ~EXEMPT)) == '0);

  // R8: exempt events follow raw activity whatever the gate state
  a_r8_exempt_pass: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (evt & EXEMPT) == ($past(raw) & EXEMPT));

endmodule

// File: rtl/coh_evt_tap.sv
module coh_evt_tap
  import cet_pkg::*;
#(
  parameter  int NUM_MST = 1,
  parameter  int NUM_SLV = 2,
  localparam int MST_BASE = GLB_W,
  localparam int SLV_BASE = GLB_W + MST_W * NUM_MST,
  localparam int BUS_W    = SLV_BASE + SLV_W * NUM_SLV
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dbg_en,
  input  logic                    sec_dbg_en,
  input  logic                    sec_observe_en,
  input  logic [GLB_W-1:0]        glb_evt,
  input  logic [NUM_MST-1:0]      m_ar_valid,
  input  logic [NUM_MST-1:0]      m_ar_ready,
  input  logic [NUM_MST-1:0]      m_ar_ns,
  input  logic [NUM_MST-1:0]      m_r_valid,
  input  logic [NUM_MST-1:0]      m_r_ready,
  input  logic [NUM_MST-1:0]      m_aw_valid,
  input  logic [NUM_MST-1:0]      m_aw_ready,
  input  logic [NUM_MST-1:0]      m_aw_ns,
  input  logic [NUM_MST-1:0]      m_w_valid,
  input  logic [NUM_MST-1:0]      m_w_ready,
  input  logic [NUM_MST-1:0]      m_b_valid,
  input  logic [NUM_MST-1:0]      m_b_ready,
  input  logic [NUM_SLV-1:0]      s_ar_valid,
  input  logic [NUM_SLV-1:0]      s_ar_ready,
  input  logic [NUM_SLV-1:0][2:0] s_ar_cls,
  input  logic [NUM_SLV-1:0]      s_ar_ns,
  input  logic [NUM_SLV-1:0]      s_r_valid,
  input  logic [NUM_SLV-1:0]      s_r_ready,
  input  logic [NUM_SLV-1:0]      s_r_last,
  input  logic [NUM_SLV-1:0]      s_r_snp_hit,
  input  logic [NUM_SLV-1:0]      s_aw_valid,
  input  logic [NUM_SLV-1:0]      s_aw_ready,
  input  logic [NUM_SLV-1:0][2:0] s_aw_cls,
  input  logic [NUM_SLV-1:0]      s_aw_ns,
  input  logic [NUM_SLV-1:0]      s_w_valid,
  input  logic [NUM_SLV-1:0]      s_w_ready,
  input  logic [NUM_SLV-1:0]      s_b_valid,
  input  logic [NUM_SLV-1:0]      s_b_ready,
  input  logic [NUM_SLV-1:0]      s_ac_valid,
  input  logic [NUM_SLV-1:0]      s_ac_ready,
  input  logic [NUM_SLV-1:0][1:0] s_ac_cls,
  input  logic [NUM_SLV-1:0]      s_ac_ns,
  input  logic [NUM_SLV-1:0]      s_cr_valid,
  input  logic [NUM_SLV-1:0]      s_cr_ready,
  input  logic [NUM_SLV-1:0]      s_cr_resp0,
  input  logic [NUM_SLV-1:0]      s_cd_valid,
  input  logic [NUM_SLV-1:0]      s_cd_ready,
  input  logic [NUM_SLV-1:0]      s_ot_stall,
  input  logic [NUM_SLV-1:0]      s_arb_stall,
  output logic [BUS_W-1:0]        evt_bus
);

  logic permit;
  logic [GLB_W-1:0] glb_q;
  logic [NUM_MST-1:0][MST_W-1:0] mst_evt;
  logic [NUM_SLV-1:0][SLV_W-1:0] slv_evt;

  assign permit = sec_observe_en | (dbg_en & sec_dbg_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glb_q <= '0;
    else        glb_q <= glb_evt;
  end

  for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
    logic [MST_W-1:0] raw, ns;

    cet_mst_src u_src (
      .ar_valid (m_ar_valid[m]), .ar_ready (m_ar_ready[m]), .ar_ns (m_ar_ns[m]),
      .r_valid  (m_r_valid[m]),  .r_ready  (m_r_ready[m]),
      .aw_valid (m_aw_valid[m]), .aw_ready (m_aw_ready[m]), .aw_ns (m_aw_ns[m]),
      .w_valid  (m_w_valid[m]),  .w_ready  (m_w_ready[m]),
      .b_valid  (m_b_valid[m]),  .b_ready  (m_b_ready[m]),
      .raw      (raw),           .ns       (ns)
    );

    cet_sec_gate #(.W(MST_W), .EXEMPT(MST_EXEMPT)) u_gate (
      .clk (clk), .rst_n (rst_n), .permit (permit),
      .raw (raw), .ns (ns), .evt (mst_evt[m])
    );
  end

  for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
    logic [SLV_W-1:0] raw, ns;
    localparam int B = SLV_BASE + SLV_W * s;

    cet_slv_src u_src (
      .clk       (clk),            .rst_n     (rst_n),
      .ar_valid  (s_ar_valid[s]),  .ar_ready  (s_ar_ready[s]),
      .ar_cls    (s_ar_cls[s]),    .ar_ns     (s_ar_ns[s]),
      .r_valid   (s_r_valid[s]),   .r_ready   (s_r_ready[s]),
      .r_last    (s_r_last[s]),    .r_snp_hit (s_r_snp_hit[s]),
      .aw_valid  (s_aw_valid[s]),  .aw_ready  (s_aw_ready[s]),
      .aw_cls    (s_aw_cls[s]),    .aw_ns     (s_aw_ns[s]),
      .w_valid   (s_w_valid[s]),   .w_ready   (s_w_ready[s]),
      .b_valid   (s_b_valid[s]),   .b_ready   (s_b_ready[s]),
      .ac_valid  (s_ac_valid[s]),  .ac_ready  (s_ac_ready[s]),
      .ac_cls    (s_ac_cls[s]),    .ac_ns     (s_ac_ns[s]),
      .cr_valid  (s_cr_valid[s]),  .cr_ready  (s_cr_ready[s]),
      .cr_resp0  (s_cr_resp0[s]),
      .cd_valid  (s_cd_valid[s]),  .cd_ready  (s_cd_ready[s]),
      .ot_stall  (s_ot_stall[s]),  .arb_stall (s_arb_stall[s]),
      .raw       (raw),            .ns        (ns)
    );

    cet_sec_gate #(.W(SLV_W), .EXEMPT(SLV_EXEMPT)) u_gate (
      .clk (clk), .rst_n (rst_n), .permit (permit),
      .raw (raw), .ns (ns), .evt (slv_evt[s])
    );

    // R1: a visible read request handshake shows up one cycle later
    a_r1_ar_hs: assert property (@(posedge clk) disable iff (!rst_n)
      s_ar_valid[s] && s_ar_ready[s] && (s_ar_ns[s] || permit)
      |=> evt_bus[B + EV_AR_HS]);

    // R4: write-evict class never produces its event
    a_r4_no_wevict: assert property (@(posedge clk) disable iff (!rst_n)
      s_aw_valid[s] && s_aw_ready[s] && s_aw_cls[s] == 3'd6
      |=> !evt_bus[B + EV_WEVICT] && evt_bus[B + EV_AW_HS] == $past(s_aw_ns[s] || permit));

    // R6: handshake and stall on one channel are exclusive
    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt_bus[B + EV_AR_HS] && evt_bus[B + EV_AR_ST]));
  end

  assign evt_bus = {slv_evt, mst_evt, glb_q};

  // R11: global events pass with one cycle of latency
  a_r11_glb: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> evt_bus[GLB_W-1:0] == $past(glb_evt));

endmodule

// File: tb/sim_coh_evt_tap.sv
`timescale 1ns/1ps
module sim_coh_evt_tap;

  localparam int NM = 1;
  localparam int NS = 2;
  localparam int SB = 16 + 7 * NM;
  localparam int BW = SB + 32 * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_en, sec_dbg_en, sec_observe_en;
  logic [15:0] glb_evt;
  logic [NM-1:0] m_ar_valid, m_ar_ready, m_ar_ns, m_r_valid, m_r_ready;
  logic [NM-1:0] m_aw_valid, m_aw_ready, m_aw_ns, m_w_valid, m_w_ready, m_b_valid, m_b_ready;
  logic [NS-1:0] s_ar_valid, s_ar_ready, s_ar_ns, s_r_valid, s_r_ready, s_r_last, s_r_snp_hit;
  logic [NS-1:0][2:0] s_ar_cls, s_aw_cls;
  logic [NS-1:0][1:0] s_ac_cls;
  logic [NS-1:0] s_aw_valid, s_aw_ready, s_aw_ns, s_w_valid, s_w_ready, s_b_valid, s_b_ready;
  logic [NS-1:0] s_ac_valid, s_ac_ready, s_ac_ns, s_cr_valid, s_cr_ready, s_cr_resp0;
  logic [NS-1:0] s_cd_valid, s_cd_ready, s_ot_stall, s_arb_stall;
  logic [BW-1:0] evt_bus;

  coh_evt_tap #(.NUM_MST(NM), .NUM_SLV(NS)) u0 (.*);

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench model state (R9)
  logic [NS-1:0] mdl_req_ns, mdl_ar_ns;
  logic [NS-1:0][31:0] exp_s;
  logic [NM-1:0][6:0]  exp_m;
  logic [15:0] exp_g;

  // exempt sets from R8
  localparam logic [31:0] S_EX = 32'h2D44_0300;
  localparam logic [6:0]  M_EX = 7'b110_1011;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string slv_req(logic [31:0] d);
    int b = 0;
    for (int i = 31; i >= 0; i--) if (d[i]) b = i;
    if (b <= 7)  return "R1";
    if (b <= 9)  return "R2";
    if (b <= 16) return "R3";
    if (b == 17) return "R4";
    if (b <= 22) return "R5";
    if (b <= 29) return "R6";
    return "R9";
  endfunction

  function automatic logic perm();
    return sec_observe_en | (dbg_en & sec_dbg_en);
  endfunction

  function automatic logic [31:0] model_slv(int s);
    logic [31:0] r, n;
    logic arh, awh, ach;
    arh = s_ar_valid[s] & s_ar_ready[s];
    awh = s_aw_valid[s] & s_aw_ready[s];
    ach = s_ac_valid[s] & s_ac_ready[s];
    r = '0;
    n = '1;
    r[0] = arh;
    if (arh && s_ar_cls[s] != 3'd7) r[1 + s_ar_cls[s]] = 1'b1;
    r[8] = s_r_valid[s] & s_r_ready[s];
    r[9] = r[8] & s_r_last[s] & s_r_snp_hit[s];
    r[10] = awh;
    if (awh && s_aw_cls[s] <= 3'd5) r[11 + s_aw_cls[s]] = 1'b1;
    r[18] = s_w_valid[s] & s_w_ready[s];
    r[19] = ach;
    r[20] = ach & (s_ac_cls[s] == 2'd0);
    r[21] = ach & (s_ac_cls[s] == 2'd1);
    r[22] = s_cr_valid[s] & s_cr_ready[s] & ~s_cr_resp0[s];
    r[23] = s_ar_valid[s] & ~s_ar_ready[s];
    r[24] = s_r_valid[s] & ~s_r_ready[s];
    r[25] = s_aw_valid[s] & ~s_aw_ready[s];
    r[26] = s_w_valid[s] & ~s_w_ready[s];
    r[27] = s_b_valid[s] & ~s_b_ready[s];
    r[28] = s_ac_valid[s] & ~s_ac_ready[s];
    r[29] = s_cd_valid[s] & ~s_cd_ready[s];
    r[30] = s_ot_stall[s];
    r[31] = s_arb_stall[s];
    for (int i = 0; i <= 7; i++) n[i] = s_ar_ns[s];
    for (int i = 10; i <= 17; i++) n[i] = s_aw_ns[s];
    for (int i = 19; i <= 21; i++) n[i] = s_ac_ns[s];
    n[23] = s_ar_ns[s];
    n[25] = s_aw_ns[s];
    n[28] = s_ac_ns[s];
    n[30] = mdl_req_ns[s];
    n[31] = mdl_ar_ns[s];
    return r & (S_EX | n | {32{perm()}});
  endfunction

  function automatic logic [6:0] model_mst(int m);
    logic [6:0] r, n;
    r[0] = m_r_valid[m] & m_r_ready[m];
    r[1] = m_w_valid[m] & m_w_ready[m];
    r[2] = m_ar_valid[m] & ~m_ar_ready[m];
    r[3] = m_r_valid[m] & ~m_r_ready[m];
    r[4] = m_aw_valid[m] & ~m_aw_ready[m];
    r[5] = m_w_valid[m] & ~m_w_ready[m];
    r[6] = m_b_valid[m] & ~m_b_ready[m];
    n = '1;
    n[2] = m_ar_ns[m];
    n[4] = m_aw_ns[m];
    return r & (M_EX | n | {7{perm()}});
  endfunction

  task automatic clear_in();
    glb_evt = '0;
    {m_ar_valid, m_ar_ready, m_ar_ns, m_r_valid, m_r_ready} = '0;
    {m_aw_valid, m_aw_ready, m_aw_ns, m_w_valid, m_w_ready, m_b_valid, m_b_ready} = '0;
    {s_ar_valid, s_ar_ready, s_ar_ns, s_r_valid, s_r_ready, s_r_last, s_r_snp_hit} = '0;
    s_ar_cls = '0; s_aw_cls = '0; s_ac_cls = '0;
    {s_aw_valid, s_aw_ready, s_aw_ns, s_w_valid, s_w_ready, s_b_valid, s_b_ready} = '0;
    {s_ac_valid, s_ac_ready, s_ac_ns, s_cr_valid, s_cr_ready, s_cr_resp0} = '0;
    {s_cd_valid, s_cd_ready, s_ot_stall, s_arb_stall} = '0;
  endtask

  task automatic drive_rand();
    glb_evt = 16'($urandom);
    for (int m = 0; m < NM; m++) begin
      {m_ar_valid[m], m_ar_ready[m], m_ar_ns[m], m_r_valid[m], m_r_ready[m]} = 5'($urandom);
      {m_aw_valid[m], m_aw_ready[m], m_aw_ns[m], m_w_valid[m], m_w_ready[m],
       m_b_valid[m], m_b_ready[m]} = 7'($urandom);
    end
    for (int s = 0; s < NS; s++) begin
      {s_ar_valid[s], s_ar_ready[s], s_ar_ns[s], s_r_valid[s], s_r_ready[s],
       s_r_last[s], s_r_snp_hit[s]} = 7'($urandom);
      {s_aw_valid[s], s_aw_ready[s], s_aw_ns[s], s_w_valid[s], s_w_ready[s],
       s_b_valid[s], s_b_ready[s]} = 7'($urandom);
      {s_ac_valid[s], s_ac_ready[s], s_ac_ns[s], s_cr_valid[s], s_cr_ready[s],
       s_cr_resp0[s], s_cd_valid[s], s_cd_ready[s], s_ot_stall[s], s_arb_stall[s]} = 10'($urandom);
      s_ar_cls[s] = 3'($urandom);
      s_aw_cls[s] = 3'($urandom);
      s_ac_cls[s] = 2'($urandom);
    end
  endtask

  // inputs already driven at a negedge: predict, advance model, compare next negedge
  task automatic step();
    for (int s = 0; s < NS; s++) exp_s[s] = model_slv(s);
    for (int m = 0; m < NM; m++) exp_m[m] = model_mst(m);
    exp_g = glb_evt;
    for (int s = 0; s < NS; s++) begin
      if (s_ar_valid[s] & s_ar_ready[s]) begin
        mdl_ar_ns[s]  = s_ar_ns[s];
        mdl_req_ns[s] = s_ar_ns[s];
      end else if (s_aw_valid[s] & s_aw_ready[s]) begin
        mdl_req_ns[s] = s_aw_ns[s];
      end
    end
    @(negedge clk);
    // R11: layout and one-cycle latency
    chk("R11", "global slice", 32'(evt_bus[15:0]), 32'(exp_g));
    for (int m = 0; m < NM; m++)
      chk("R10", "master slice", 32'(evt_bus[16 + 7 * m +: 7]), 32'(exp_m[m]));
    for (int s = 0; s < NS; s++)
      chk(slv_req(evt_bus[SB + 32 * s +: 32] ^ exp_s[s]), "slave slice",
          evt_bus[SB + 32 * s +: 32], exp_s[s]);
  endtask

  initial begin
    clear_in();
    dbg_en = 1'b0; sec_dbg_en = 1'b0; sec_observe_en = 1'b0;
    mdl_req_ns = '0; mdl_ar_ns = '0;
    repeat (3) @(negedge clk);
    chk("R12", "bus in reset", 32'(evt_bus[31:0]), 32'h0);
    chk("R12", "bus upper in reset", 32'(evt_bus[BW-1:SB]), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "bus after reset", 32'(evt_bus[BW-1:SB] | evt_bus[31:0]), 32'h0);

    // R9 prologue: gate closed, no request accepted yet, stall inputs high
    s_ot_stall[0] = 1'b1; s_arb_stall[0] = 1'b1;
    s_r_valid[0] = 1'b1; s_r_ready[0] = 1'b1; s_r_last[0] = 1'b1; s_r_snp_hit[0] = 1'b1;
    step();
    chk("R9", "reset-secure stalls dropped", 32'(evt_bus[SB + 30 +: 2]), 32'h0);
    chk("R8", "exempt read data with gate closed", 32'(evt_bus[SB + 8 +: 2]), 32'h3);
    // R7: Secure read request under closed gate, then open via dbg pair
    clear_in();
    s_ar_valid[0] = 1'b1; s_ar_ready[0] = 1'b1; s_ar_cls[0] = 3'd3;
    step();
    chk("R7", "secure request dropped", 32'(evt_bus[SB +: 5]), 32'h0);
    dbg_en = 1'b1; sec_dbg_en = 1'b1;
    step();
    chk("R7", "secure request with debug pair", 32'(evt_bus[SB +: 5]), 32'h11);
    // R4: write-evict class, non-secure
    clear_in();
    dbg_en = 1'b0; sec_dbg_en = 1'b0;
    s_aw_valid[1] = 1'b1; s_aw_ready[1] = 1'b1; s_aw_ns[1] = 1'b1; s_aw_cls[1] = 3'd6;
    step();
    chk("R4", "write-evict only base bit", 32'(evt_bus[SB + 32 + 10 +: 8]), 32'h01);

    // sweep across four authorisation phases (R7, R8, R9 inside the model)
    for (int ph = 0; ph < 4; ph++) begin
      case (ph)
        0: begin dbg_en = 1'b0; sec_dbg_en = 1'b0; sec_observe_en = 1'b0; end
        1: begin dbg_en = 1'b1; sec_dbg_en = 1'b0; sec_observe_en = 1'b0; end
        2: begin dbg_en = 1'b0; sec_dbg_en = 1'b1; sec_observe_en = 1'b1; end
        default: begin dbg_en = 1'b1; sec_dbg_en = 1'b1; sec_observe_en = 1'b0; end
      endcase
      for (int i = 0; i < 1500; i++) begin
        drive_rand();
        step();
      end
    end
    // mixed gate toggling every cycle
    for (int i = 0; i < 1500; i++) begin
      drive_rand();
      {dbg_en, sec_dbg_en, sec_observe_en} = 3'($urandom);
      step();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule